// File: doc/BRIEF.md
# Wake Reason Capture Register

This block keeps a sticky record of why the device came out of, or never fully went into, a low-power state. It takes the live wakeup request lines and an enable mask, and shows their masked AND on a status output straight away. Once a valid low-power entry has started, every enabled request, and every pulse that flags a failed entry, sets its own bit in a reason vector. Each pulse is either a fall-through (an interrupt broke the core out of its wait just as entry was underway) or an abort (a non-volatile memory, life-cycle or fuse transaction was still in progress).

Recording stays armed after entry starts, so later events add to the record instead of replacing it. Software can stop recording with a disable bit. It clears reason bits by writing ones to them on a one-cycle write strobe. Clock-domain crossing and the logic that detects fall-through and abort are handled elsewhere.

Top module: `wake_reason_capture`

## Requirements
- R1: `wake_status_o` equals `wake_req_i & wake_en_i` bit for bit, in the same cycle and with no register on the path.
- R2: The reason vector has `NUM_WAKE+2` bits. Bit i (i < NUM_WAKE) belongs to wakeup source i, bit NUM_WAKE records a fall-through pulse and bit NUM_WAKE+1 records an abort pulse.
- R3: After reset the reason vector is all zeros and recording is disarmed. Requests, fall-through and abort pulses that arrive before any entry start leave the vector unchanged.
- R4: A cycle with `entry_start_i` high and `capture_dis_i` low arms recording, and that cycle already records. While armed, every clock edge records the masked status bits and the two pulse inputs, and the result shows on `reasons_o` one cycle later.
- R5: Recorded bits are sticky. New events are ORed into the stored vector, so several reasons can be held together, and a bit stays set after its source drops.
- R6: In any cycle with `capture_dis_i` high, nothing is recorded and recording is disarmed, even if `entry_start_i` is high in that cycle. After the disable is lowered again, recording stays off until the next entry start.
- R7: A cycle with `clr_we_i` high clears every reason bit whose `clr_data_i` bit is 1 and leaves the other bits alone. When `clr_we_i` is low, `clr_data_i` has no effect.
- R8: If a clear and a new record hit the same bit in the same cycle, the bit is set afterwards.
- R9: A request whose enable bit is 0 is never recorded, even while recording is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_req_i | input | NUM_WAKE | Live wakeup requests |
| wake_en_i | input | NUM_WAKE | Per-source wakeup enable mask |
| entry_start_i | input | 1 | Pulse: a valid low-power entry has begun |
| fall_through_i | input | 1 | Pulse: entry halted by an interrupt during the wait |
| abort_i | input | 1 | Pulse: entry halted by a pending memory/life-cycle/fuse transaction |
| capture_dis_i | input | 1 | Software suppression of reason recording |
| clr_we_i | input | 1 | Write strobe for the write-one-to-clear port |
| clr_data_i | input | NUM_WAKE+2 | Bits to clear when `clr_we_i` is high |
| wake_status_o | output | NUM_WAKE | Masked wakeup requests |
| reasons_o | output | NUM_WAKE+2 | Accumulated reason vector |

## Verification
The arm flag is visible only through what it lets into the vector. A stuck or wrongly set arm state therefore appears on `reasons_o` one cycle after the first enabled request, fall-through or abort pulse that should have been recorded or dropped. A reason cell with the wrong clear or priority logic shows up in the cycle after a strobe or a clear-versus-set collision. The bench compares both outputs against a behavioural model in every cycle, so any such fault is caught in the first cycle it becomes visible.

// File: rtl/wrc_pkg.sv
`timescale 1ns/1ps
package wrc_pkg;
   localparam int unsigned EXTRA_REASONS = 2;
   localparam int unsigned FT_OFFSET     = 0;   // fall-through sits just above the sources
   localparam int unsigned AB_OFFSET     = 1;   // abort sits above fall-through

   function automatic int unsigned reason_width(input int unsigned n_src);
      return n_src + EXTRA_REASONS;
   endfunction
endpackage

// File: rtl/wrc_status_mask.sv
`timescale 1ns/1ps
module wrc_status_mask #(
   parameter int unsigned NUM_WAKE = 6
) (
   input  logic [NUM_WAKE-1:0] req_i,
   input  logic [NUM_WAKE-1:0] en_i,
   output logic [NUM_WAKE-1:0] status_o
);
   for (genvar i = 0; i < NUM_WAKE; i++) begin : g_bit
      assign status_o[i] = req_i[i] & en_i[i];
   end
endmodule

// File: rtl/wrc_capture_ctrl.sv
`timescale 1ns/1ps
module wrc_capture_ctrl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic dis_i,
   output logic armed_o,
   output logic record_o
);
   logic armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed_q <= 1'b0;
      else         armed_q <= !dis_i && (start_i || armed_q);
   end

   assign armed_o  = armed_q;
   assign record_o = !dis_i && (start_i || armed_q);

   AST_DIS_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dis_i |=> !armed_o); // R6
   AST_ARM_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(armed_o) |-> $past(start_i)); // R4
endmodule

// File: rtl/wrc_reason_cell.sv
`timescale 1ns/1ps
module wrc_reason_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i | (q & ~clr_i);
   end

   assign q_o = q;

   AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o && !clr_i) |=> q_o); // R5
   AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !q_o); // R7
   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> q_o); // R8
endmodule

// File: rtl/wake_reason_capture.sv
`timescale 1ns/1ps
module wake_reason_capture
   import wrc_pkg::*;
#(
   parameter int unsigned NUM_WAKE = 6,
   localparam int unsigned RW      = reason_width(NUM_WAKE)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_WAKE-1:0] wake_req_i,
   input  logic [NUM_WAKE-1:0] wake_en_i,
   input  logic                entry_start_i,
   input  logic                fall_through_i,
   input  logic                abort_i,
   input  logic                capture_dis_i,
   input  logic                clr_we_i,
   input  logic [RW-1:0]       clr_data_i,
   output logic [NUM_WAKE-1:0] wake_status_o,
   output logic [RW-1:0]       reasons_o
);
   initial begin : p_param_check
      if (NUM_WAKE < 1 || NUM_WAKE > 30)
         $fatal(1, "NUM_WAKE must lie in 1..30");
   end

   logic          armed;
   logic          record;
   logic [RW-1:0] events;

   wrc_status_mask #(.NUM_WAKE(NUM_WAKE)) u_mask (
      .req_i    (wake_req_i),
      .en_i     (wake_en_i),
      .status_o (wake_status_o)
   );

   wrc_capture_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (entry_start_i),
      .dis_i    (capture_dis_i),
      .armed_o  (armed),
      .record_o (record)
   );

   assign events[NUM_WAKE-1:0]        = wake_status_o;
   assign events[NUM_WAKE+FT_OFFSET]  = fall_through_i;
   assign events[NUM_WAKE+AB_OFFSET]  = abort_i;

   for (genvar i = 0; i < RW; i++) begin : g_cell
      wrc_reason_cell u_cell (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .set_i  (record & events[i]),
         .clr_i  (clr_we_i & clr_data_i[i]),
         .q_o    (reasons_o[i])
      );
   end

   AST_STATUS_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_status_o & ~wake_en_i) == '0 && (wake_status_o & ~wake_req_i) == '0); // R1
   AST_DISABLED_NO_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (capture_dis_i && reasons_o == '0) |=> reasons_o == '0); // R6
   AST_IDLE_NO_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!armed && !entry_start_i && reasons_o == '0) |=> reasons_o == '0); // R3
   AST_MASKED_SRC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reasons_o[NUM_WAKE-1:0] == '0 && wake_en_i == '0) |=> reasons_o[NUM_WAKE-1:0] == '0); // R9
endmodule

// File: tb/tb_wake_reason_capture.sv
`timescale 1ns/1ps
module tb_wake_reason_capture;
   localparam int N  = 6;
   localparam int RW = N + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0, en = '0;
   logic          start = 1'b0, ft = 1'b0, ab = 1'b0, dis = 1'b0, cwe = 1'b0;
   logic [RW-1:0] cdata = '0;
   logic [N-1:0]  status;
   logic [RW-1:0] reasons;

   int n_chk  = 0;
   int n_fail = 0;

   logic [RW-1:0] m_reasons = '0;
   bit            m_armed   = 0;

   always #10 clk = ~clk;

   wake_reason_capture #(.NUM_WAKE(N)) dut (
      .clk_i(clk), .rst_ni(rst_n), .wake_req_i(req), .wake_en_i(en),
      .entry_start_i(start), .fall_through_i(ft), .abort_i(ab),
      .capture_dis_i(dis), .clr_we_i(cwe), .clr_data_i(cdata),
      .wake_status_o(status), .reasons_o(reasons)
   );

   task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One clock cycle: drive, check status, clock, update model, check reasons.
   task automatic step(input string tag, input logic [N-1:0] r, input logic [N-1:0] e,
                       input bit s, input bit f, input bit a, input bit d,
                       input bit w, input logic [RW-1:0] c);
      logic [RW-1:0] evts;
      bit            rec;
      req = r; en = e; start = s; ft = f; ab = a; dis = d; cwe = w; cdata = c;
      #2;
      check("R1", {2'b00, status}, {2'b00, r & e});
      @(posedge clk);
      rec  = !d && (s || m_armed);
      evts = rec ? {a, f, r & e} : '0;
      m_reasons = (m_reasons & ~(w ? c : '0)) | evts;
      m_armed   = !d && (s || m_armed);
      @(negedge clk);
      check(tag, reasons, m_reasons);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check("R3", reasons, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3", reasons, '0);
      // Idle: requests and pulses before any entry start are dropped (R3)
      step("R3", 6'h3F, 6'h3F, 0, 1, 1, 0, 0, '0);
      step("R3", 6'h05, 6'h0F, 0, 0, 0, 0, 0, '0);
      // Start with a live enabled request: recorded in the start cycle (R4)
      step("R4", 6'h02, 6'h0F, 1, 0, 0, 0, 0, '0);
      step("R4", 6'h00, 6'h0F, 0, 0, 0, 0, 0, '0);
      // Masked request is not recorded (R9)
      step("R9", 6'h30, 6'h0F, 0, 0, 0, 0, 0, '0);
      // Accumulation, then source drops (R5)
      step("R5", 6'h08, 6'h0F, 0, 0, 0, 0, 0, '0);
      step("R5", 6'h00, 6'h00, 0, 0, 0, 0, 0, '0);
      // Fall-through lands on bit N, abort on bit N+1 (R2)
      step("R2", 6'h00, 6'h00, 0, 1, 0, 0, 0, '0);
      step("R2", 6'h00, 6'h00, 0, 0, 1, 0, 0, '0);
      check("R2", reasons, 8'hCA);
      // Clear data without strobe is ignored (R7)
      step("R7", 6'h00, 6'h00, 0, 0, 0, 0, 0, 8'hFF);
      // Clear a subset (R7)
      step("R7", 6'h00, 6'h00, 0, 0, 0, 0, 1, 8'h42);
      check("R7", reasons, 8'h88);
      // Clear and record collide on bit 3 and on abort (R8)
      step("R8", 6'h08, 6'h0F, 0, 0, 1, 0, 1, 8'h88);
      check("R8", reasons, 8'h88);
      // Disable: nothing recorded, stays disarmed after release (R6)
      step("R6", 6'h01, 6'h3F, 0, 1, 0, 1, 0, '0);
      step("R6", 6'h01, 6'h3F, 0, 0, 1, 0, 0, '0);
      step("R6", 6'h10, 6'h3F, 1, 0, 0, 1, 0, '0);
      step("R6", 6'h10, 6'h3F, 0, 0, 0, 0, 0, '0);
      check("R6", reasons, 8'h88);
      // Re-arm with a new start (R4)
      step("R4", 6'h00, 6'h3F, 1, 0, 0, 0, 1, 8'hFF);
      step("R4", 6'h21, 6'h3F, 0, 1, 0, 0, 0, '0);
      check("R4", reasons, 8'h61);
      // Varied status patterns while armed (R1, R5)
      for (int k = 0; k < 16; k++) begin
         step("R5", 6'(k * 7), 6'(k * 13 + 5), 0, k[0], k[1] & k[2], 0, k[3], 8'(k * 29));
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule